// File: doc/BRIEF.md
# Dirty-Tracked Register Context Saver

This block owns a bank of eight optional 48-bit registers, such as a floating-point register file, and moves them to and from a context area in memory when the operating system switches between processes. Each register carries a dirty flag. The flag follows the register's content: it is set when a non-zero value is written and cleared when the value is zero. A save or restore can therefore skip registers that hold nothing. Every switch handles the whole bank. Nothing is deferred until later use.

A save writes one flag word to the base address. It then writes only the dirty registers, each as three consecutive 16-bit words. A restore reads the flag word back and loads only the registers it marks. All other registers are forced to zero, so no value from the previous process survives the switch. The datapath writes registers through a simple write port and reads them through a combinational read port. While an operation is running, datapath writes and new commands are refused.

Top module: `ctx_spill_unit`

## Requirements
- R1: After reset all registers read zero, `dirty_o` is all zero, and `busy`, `done` and `mem_req` are low.
- R2: A datapath write of register i sets `dirty_o[i]` to 1 when the value is non-zero and to 0 when it is zero. The new value is visible on `rd_data` in the next cycle.
- R3: A save first writes the flag word to `base_addr`. Bit i is the dirty flag of register i, and bits 15..8 are zero.
- R4: After the flag word, a save writes each dirty register in ascending index order, skipping clean ones. Each takes three words, least significant first. The k-th dirty register occupies `base_addr+1+3k` to `base_addr+3+3k`, with no gaps.
- R5: Each transfer takes one clock, and the transfers of one operation occupy consecutive cycles at consecutive addresses. `done` is high for exactly one cycle, the cycle right after the final transfer. With N registers flagged, an operation holds `mem_req` for 1+3N cycles.
- R6: If no register is flagged, the operation makes only the flag-word transfer, and `done` follows in the next cycle.
- R7: A restore first reads the flag word at `base_addr`, using bits 7..0 and ignoring bits 15..8. It then reads three words per flagged register, in ascending order with the same layout as R4, and loads them into that register.
- R8: A restore leaves every register not flagged at zero with its dirty bit clear. A loaded register ends dirty exactly when its restored value is non-zero.
- R9: While `busy` is high, datapath writes, `save_req` and `restore_req` are ignored.
- R10: If `save_req` and `restore_req` arrive in the same idle cycle, the save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Datapath register write strobe |
| wr_idx | input | 3 | Register written by the datapath |
| wr_data | input | 48 | Value written by the datapath |
| rd_idx | input | 3 | Register selected for reading |
| rd_data | output | 48 | Value of the selected register |
| dirty_o | output | 8 | Current dirty flags, bit i for register i |
| save_req | input | 1 | Start a save (one-cycle pulse) |
| restore_req | input | 1 | Start a restore (one-cycle pulse) |
| base_addr | input | 16 | Word address of the context area |
| busy | output | 1 | Save or restore in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| mem_req | output | 1 | Memory word transfer this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle of the request |

## Verification
The hardest case to reach is a restore whose flag word disagrees with the data stored after it. This includes a flag word with junk in its upper byte, and a flagged register whose three saved words are all zero. A correct save never produces either. The bench reaches them by writing the memory model directly before starting the restore. It then checks the register values, the dirty flags and the transfer count. Datapath writes and commands that arrive mid-save are timed one cycle into the operation. That is the cycle where a missing write block would corrupt both the register and the saved image.

// File: rtl/ctx_spill_pkg.sv
package ctx_spill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FLAG = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

  // Lowest set bit of mask at or above position from; returns 16 when none.
  function automatic logic [4:0] next_dirty(input logic [15:0] mask,
                                            input logic [4:0]  from);
    logic [4:0] res;
    res = 5'd16;
    for (int i = 15; i >= 0; i--) begin
      if (mask[i] && (5'(i) >= from)) res = 5'(i);
    end
    return res;
  endfunction

endpackage

// File: rtl/ctx_reg_bank.sv
module ctx_reg_bank #(
  parameter int NREG = 8,
  parameter int DW   = 48,
  parameter int MW   = 16,
  localparam int IW   = $clog2(NREG),
  localparam int WPR  = DW / MW,
  localparam int WSEL = (WPR > 1) ? $clog2(WPR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 clr_all,
  input  logic                 ld_en,
  input  logic [IW-1:0]        ld_idx,
  input  logic [WSEL-1:0]      ld_word,
  input  logic [MW-1:0]        ld_data,
  input  logic [IW-1:0]        rd_a_idx,
  output logic [DW-1:0]        rd_a_data,
  input  logic [IW-1:0]        rd_b_idx,
  output logic [DW-1:0]        rd_b_data,
  output logic [NREG-1:0]      dirty,
  output logic [NREG*DW-1:0]   regs_flat
);

  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] ld_val;

    always_comb begin
      ld_val = regs[i];
      for (int w = 0; w < WPR; w++) begin
        if (ld_word == WSEL'(w)) ld_val[w*MW +: MW] = ld_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        regs[i]  <= '0;
        dirty[i] <= 1'b0;
      end else if (ld_en && ld_idx == IW'(i)) begin
        regs[i]  <= ld_val;
        dirty[i] <= |ld_val;
      end else if (wr_en && wr_idx == IW'(i)) begin
        regs[i]  <= wr_data;
        dirty[i] <= |wr_data;
      end
    end

    assign regs_flat[i*DW +: DW] = regs[i];
  end

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

endmodule

// File: rtl/ctx_xfer_seq.sv
module ctx_xfer_seq
  import ctx_spill_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 48,
  parameter int MW   = 16,
  parameter int AW   = 16,
  localparam int IW   = $clog2(NREG),
  localparam int WPR  = DW / MW,
  localparam int WSEL = (WPR > 1) ? $clog2(WPR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [AW-1:0]    base_addr,
  input  logic [NREG-1:0]  dirty,
  input  logic [DW-1:0]    reg_val,
  output logic [IW-1:0]    cur_idx,
  input  logic [MW-1:0]    mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [MW-1:0]    mem_wdata,
  output logic             clr_all,
  output logic             ld_en,
  output logic [WSEL-1:0]  ld_word,
  output logic [MW-1:0]    ld_data,
  output logic             busy,
  output logic             done,
  output logic             flag_phase
);

  seq_state_e        st;
  logic              is_save;
  logic [NREG-1:0]   flags;
  logic [IW-1:0]     idx;
  logic [WSEL-1:0]   wcnt;
  logic [AW-1:0]     addr;
  logic              done_q;

  logic [NREG-1:0]   flag_src;
  logic [15:0]       first_mask, rest_mask;
  logic [4:0]        first_hit, next_hit;
  logic [MW-1:0]     flag_word, data_word;

  always_comb begin
    flag_src   = is_save ? flags : mem_rdata[NREG-1:0];
    first_mask = '0;
    first_mask[NREG-1:0] = flag_src;
    rest_mask  = '0;
    rest_mask[NREG-1:0] = flags;
    first_hit  = next_dirty(first_mask, 5'd0);
    next_hit   = next_dirty(rest_mask, 5'(idx) + 5'd1);
  end

  always_comb begin
    flag_word = '0;
    flag_word[NREG-1:0] = flags;
    data_word = '0;
    for (int w = 0; w < WPR; w++) begin
      if (wcnt == WSEL'(w)) data_word = reg_val[w*MW +: MW];
    end
  end

  assign flag_phase = (st == ST_FLAG);
  assign busy       = (st != ST_IDLE);
  assign mem_req    = busy;
  assign mem_we     = is_save;
  assign mem_addr   = addr;
  assign mem_wdata  = flag_phase ? flag_word : data_word;
  assign clr_all    = flag_phase && !is_save;
  assign ld_en      = (st == ST_XFER) && !is_save;
  assign ld_word    = wcnt;
  assign ld_data    = mem_rdata;
  assign cur_idx    = idx;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      is_save <= 1'b0;
      flags   <= '0;
      idx     <= '0;
      wcnt    <= '0;
      addr    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (save_req) begin
            is_save <= 1'b1;
            flags   <= dirty;
            addr    <= base_addr;
            st      <= ST_FLAG;
          end else if (restore_req) begin
            is_save <= 1'b0;
            addr    <= base_addr;
            st      <= ST_FLAG;
          end
        end
        ST_FLAG: begin
          flags <= flag_src;
          addr  <= addr + AW'(1);
          wcnt  <= '0;
          if (first_hit != 5'd16) begin
            idx <= first_hit[IW-1:0];
            st  <= ST_XFER;
          end else begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_XFER: begin
          addr <= addr + AW'(1);
          if (wcnt == WSEL'(WPR - 1)) begin
            wcnt <= '0;
            if (next_hit != 5'd16) begin
              idx <= next_hit[IW-1:0];
            end else begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            wcnt <= wcnt + WSEL'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctx_spill_unit.sv
module ctx_spill_unit #(
  parameter int NREG = 8,
  parameter int DW   = 48,
  parameter int MW   = 16,
  parameter int AW   = 16,
  localparam int IW   = $clog2(NREG),
  localparam int WPR  = DW / MW,
  localparam int WSEL = (WPR > 1) ? $clog2(WPR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [NREG-1:0]  dirty_o,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [AW-1:0]    base_addr,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [MW-1:0]    mem_wdata,
  input  logic [MW-1:0]    mem_rdata
);

  logic                 clr_all, ld_en, flag_phase;
  logic [WSEL-1:0]      ld_word;
  logic [MW-1:0]        ld_data;
  logic [IW-1:0]        cur_idx;
  logic [DW-1:0]        cur_val;
  logic [NREG*DW-1:0]   regs_flat;
  logic                 dp_wr_ok;

  // R9: datapath writes only land while no operation runs
  assign dp_wr_ok = wr_en && !busy;

  ctx_reg_bank #(.NREG(NREG), .DW(DW), .MW(MW)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dp_wr_ok),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .clr_all   (clr_all),
    .ld_en     (ld_en),
    .ld_idx    (cur_idx),
    .ld_word   (ld_word),
    .ld_data   (ld_data),
    .rd_a_idx  (rd_idx),
    .rd_a_data (rd_data),
    .rd_b_idx  (cur_idx),
    .rd_b_data (cur_val),
    .dirty     (dirty_o),
    .regs_flat (regs_flat)
  );

  ctx_xfer_seq #(.NREG(NREG), .DW(DW), .MW(MW), .AW(AW)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .base_addr   (base_addr),
    .dirty       (dirty_o),
    .reg_val     (cur_val),
    .cur_idx     (cur_idx),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .clr_all     (clr_all),
    .ld_en       (ld_en),
    .ld_word     (ld_word),
    .ld_data     (ld_data),
    .busy        (busy),
    .done        (done),
    .flag_phase  (flag_phase)
  );

endmodule

// File: rtl/ctx_spill_chk.sv
module ctx_spill_chk #(
  parameter int NREG = 8,
  parameter int DW   = 48,
  parameter int AW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               save_req,
  input logic               restore_req,
  input logic [AW-1:0]      base_addr,
  input logic               wr_en,
  input logic               busy,
  input logic               done,
  input logic               mem_req,
  input logic               mem_we,
  input logic [AW-1:0]      mem_addr,
  input logic [NREG-1:0]    dirty_o,
  input logic [NREG*DW-1:0] regs_flat,
  input logic               flag_phase
);

  p_save_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !busy) |=> (mem_req && mem_we && flag_phase && mem_addr == $past(base_addr)));

  p_restore_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !busy) |=> (mem_req && !mem_we && mem_addr == $past(base_addr)));

  p_save_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req && !busy) |=> mem_we);

  p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_req && $past(mem_req)));

  p_empty_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_phase && mem_we && dirty_o == '0) |=> done);

  p_save_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we && wr_en) |=> $stable(regs_flat));

  for (genvar i = 0; i < NREG; i++) begin : g_dz
    p_dirty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_o[i] == (|regs_flat[i*DW +: DW]));
  end

endmodule

bind ctx_spill_unit ctx_spill_chk #(.NREG(NREG), .DW(DW), .AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_req    (save_req),
  .restore_req (restore_req),
  .base_addr   (base_addr),
  .wr_en       (wr_en),
  .busy        (busy),
  .done        (done),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .dirty_o     (dirty_o),
  .regs_flat   (regs_flat),
  .flag_phase  (flag_phase)
);

// File: tb/ctx_spill_unit_tb_top.sv
module ctx_spill_unit_tb_top;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [47:0] wr_data;
  logic [2:0]  rd_idx;
  logic [47:0] rd_data;
  logic [7:0]  dirty_o;
  logic        save_req, restore_req;
  logic [15:0] base_addr;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  ctx_spill_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .dirty_o(dirty_o),
    .save_req(save_req), .restore_req(restore_req), .base_addr(base_addr),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [15:0] ram [64];
  always @(posedge clk) if (mem_req && mem_we) ram[mem_addr[5:0]] <= mem_wdata;
  assign mem_rdata = ram[mem_addr[5:0]];

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // value pattern for register i; never zero for the seeds used
  function automatic logic [47:0] pat(input logic [47:0] seed, input int i);
    return seed ^ (48'(i + 1) << 40);
  endfunction

  // {base[5:0], mask[7:0], seed[47:0]}
  localparam logic [61:0] VEC [6] = '{
    {6'd0,  8'hFF, 48'h0000_0000_0001},
    {6'd8,  8'h81, 48'hFFFF_FFFF_FFF0},
    {6'd33, 8'h5A, 48'h1234_5678_9ABC},
    {6'd20, 8'h01, 48'h8000_0000_0000},
    {6'd40, 8'h80, 48'h0000_FFFF_0000},
    {6'd2,  8'h3C, 48'hA5A5_5A5A_0F0F}
  };

  task automatic wr_reg(input int i, input logic [47:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(i); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input int i, output logic [47:0] v);
    rd_idx = 3'(i);
    #1;
    v = rd_data;
  endtask

  task automatic run_op(input bit do_save, input logic [15:0] b,
                        output int cyc, output int nreq);
    @(negedge clk);
    base_addr = b;
    save_req = do_save; restore_req = !do_save;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    cyc  = 1;
    nreq = mem_req ? 1 : 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (mem_req) nreq++;
    end
    if (cyc >= 200) chk("R5 op never finished", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] v;
    int cyc, nreq, k, n;
    logic [5:0] b;
    logic [7:0] m;
    logic [47:0] seed;

    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    save_req = 1'b0; restore_req = 1'b0; base_addr = '0;
    for (int j = 0; j < 64; j++) ram[j] = 16'hDEAD;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dirty", dirty_o, 0);
    chk("R1 busy/done/mem_req", {busy, done, mem_req}, 0);
    for (int i = 0; i < 8; i++) begin
      rd_reg(i, v);
      chk("R1 reg zero", v, 0);
    end

    // Table of patterns: save, check image, scramble, restore, check bank
    for (int t = 0; t < 6; t++) begin
      b = VEC[t][61:56]; m = VEC[t][55:48]; seed = VEC[t][47:0];
      n = $countones(m);
      for (int i = 0; i < 8; i++) wr_reg(i, m[i] ? pat(seed, i) : 48'd0);
      @(negedge clk);
      chk("R2 dirty follows writes", dirty_o, m);
      rd_reg(7, v);
      chk("R2 readback", v, m[7] ? pat(seed, 7) : 48'd0);
      for (int j = 0; j < 64; j++) ram[j] = 16'hDEAD;
      run_op(1'b1, 16'(b), cyc, nreq);
      chk("R5 save done cycle", cyc, 2 + 3 * n);
      chk("R5 save transfers", nreq, 1 + 3 * n);
      chk("R3 flag word", ram[b], {8'h00, m});
      k = 0;
      for (int i = 0; i < 8; i++) begin
        if (m[i]) begin
          v = pat(seed, i);
          for (int w = 0; w < 3; w++)
            chk("R4 packed word", ram[6'(b + 1 + 3 * k + w)], v[w*16 +: 16]);
          k++;
        end
      end
      if (b + 1 + 3 * n < 64) chk("R4 no extra word", ram[6'(b + 1 + 3 * n)], 16'hDEAD);
      for (int i = 0; i < 8; i++) wr_reg(i, 48'h1111_0000_0000 | 48'(i));
      run_op(1'b0, 16'(b), cyc, nreq);
      chk("R5 restore done cycle", cyc, 2 + 3 * n);
      @(negedge clk);
      chk("R8 dirty after restore", dirty_o, m);
      for (int i = 0; i < 8; i++) begin
        rd_reg(i, v);
        chk(m[i] ? "R7 loaded value" : "R8 clean zeroed", v, m[i] ? pat(seed, i) : 48'd0);
      end
    end

    // R7: upper flag bits ignored
    for (int i = 0; i < 8; i++) wr_reg(i, 48'h2222_0000_0000 | 48'(i));
    ram[0] = 16'hFF05;
    ram[1] = 16'h0001; ram[2] = 16'h0000; ram[3] = 16'h0000;
    ram[4] = 16'h0002; ram[5] = 16'h0003; ram[6] = 16'h0004;
    run_op(1'b0, 16'd0, cyc, nreq);
    chk("R7 upper flag bits ignored (transfers)", nreq, 7);
    @(negedge clk);
    chk("R7 dirty from low byte", dirty_o, 8'h05);
    rd_reg(0, v); chk("R7 reg0", v, 48'h1);
    rd_reg(2, v); chk("R7 reg2", v, 48'h0004_0003_0002);
    rd_reg(5, v); chk("R8 reg5 zeroed", v, 0);

    // R8: flagged register whose stored image is zero ends clean
    ram[10] = 16'h0002; ram[11] = 0; ram[12] = 0; ram[13] = 0;
    run_op(1'b0, 16'd10, cyc, nreq);
    chk("R8 zero image cycles", cyc, 5);
    @(negedge clk);
    chk("R8 zero image dirty", dirty_o, 0);
    rd_reg(1, v); chk("R8 zero image value", v, 0);

    // R6: nothing dirty
    ram[60] = 16'hDEAD; ram[61] = 16'hDEAD;
    run_op(1'b1, 16'd60, cyc, nreq);
    chk("R6 empty save cycles", cyc, 2);
    chk("R6 empty save transfers", nreq, 1);
    chk("R6 flag word", ram[60], 0);
    chk("R6 nothing after flag", ram[61], 16'hDEAD);

    // R9: write and restore request during a save are ignored
    wr_reg(1, 48'h5); wr_reg(6, 48'h7);
    @(negedge clk);
    base_addr = 16'd10; save_req = 1'b1;
    @(negedge clk);
    save_req = 1'b0;
    wr_en = 1'b1; wr_idx = 3'd1; wr_data = 48'd0; restore_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; restore_req = 1'b0;
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    rd_reg(1, v);
    chk("R9 write during busy ignored", v, 48'h5);
    chk("R9 dirty unchanged", dirty_o, 8'h42);
    chk("R9 saved flag", ram[10], 16'h0042);
    chk("R9 saved reg1 word0", ram[11], 16'h0005);
    chk("R9 saved reg6 word0", ram[14], 16'h0007);
    k = 0;
    for (int j = 0; j < 3; j++) begin @(negedge clk); if (mem_req) k++; end
    chk("R9 restore during busy not queued", k, 0);

    // R10: both requests in one idle cycle
    @(negedge clk);
    base_addr = 16'd50; save_req = 1'b1; restore_req = 1'b1;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    chk("R10 save wins", {mem_req, mem_we}, 2'b11);
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk("R10 flag word written", ram[50], 16'h0042);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule